// File: doc/BRIEF.md
# Single-Cycle Three-Operand Integer Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. It handles a small load/store instruction set in three 32-bit encodings: register-to-register, register-with-immediate, and long jump. The first six bits of a word select its encoding. The core holds a 32-entry register file, a word-wide instruction store and a word-wide data store. The register file and both stores are read combinationally. The register file, the data store and the program counter are updated on the rising clock edge.

A program is written into the instruction store through a dedicated write port while the core is held in reset. When reset is released, the core starts fetching at address zero. A debug port shows the current program counter and the contents of any one register, selected combinationally. A harness can therefore run a program and then compare the machine state against a model.

Top module: `sc_core`

## Requirements
- R1: On a rising edge with `rst_n` low, the program counter becomes 0, registers 1 to 31 become 0 and every data-store word becomes 0. Instruction-store contents are preserved across reset.
- R2: Register 0 always reads as zero. Any instruction that targets it leaves it at zero.
- R3: Word layout from bit 31 down: op[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6], funct[5:0], with imm[15:0] and jump field[25:0] overlaid on the low bits. With op 0x00, funct 0x20 writes rs+rt to rd and funct 0x22 writes rs−rt to rd. Both wrap modulo 2^32, and execution continues normally when the result overflows.
- R4: With op 0x00, funct 0x24 writes rs AND rt, funct 0x25 writes rs OR rt and funct 0x27 writes NOT(rs OR rt) to rd. A NOR with register 0 yields the bitwise complement.
- R5: With op 0x00, funct 0x00 writes rt shifted left by shamt and funct 0x02 writes rt shifted right by shamt to rd. Both shifts fill with zeros.
- R6: Op 0x08 writes rs plus the sign-extended imm to rt. Op 0x0C writes rs AND the zero-extended imm to rt. Op 0x0D writes rs OR the zero-extended imm to rt.
- R7: Op 0x23 loads the 32-bit word at byte address rs + sign-extended imm into rt. Op 0x2B stores rt to that address. Address bits [1:0] are ignored. Only a store writes the data store.
- R8: Op 0x04 (when rs equals rt) and op 0x05 (when rs differs from rt) set the next PC to PC+4+(sign-extended imm << 2). Otherwise the next PC is PC+4.
- R9: Op 0x02 sets the next PC to {(PC+4)[31:28], jump field, 2'b00}.
- R10: An op, or an op-0x00 funct, outside the codes listed in R3 to R9 changes no register and no data-store word. It only advances the PC by 4.
- R11: Every instruction other than a branch or a jump advances the PC by exactly 4. A word written via `prog_we` at word index `prog_addr` is fetched at byte address 4×`prog_addr`.
- R12: `dbg_pc` shows the current PC, and `dbg_reg_data` shows the register selected by `dbg_reg_sel` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we | input | 1 | Write enable for the instruction store |
| prog_addr | input | $clog2(IMEM_WORDS) | Word index written by the program port |
| prog_data | input | 32 | Instruction word to write |
| dbg_reg_sel | input | 5 | Register observed on the debug port |
| dbg_reg_data | output | 32 | Value of the selected register |
| dbg_pc | output | 32 | Current program counter |

## Verification
The bench targets sums that cross the sign boundary. A core that traps or saturates there would leave the destination unwritten or stop advancing. It checks that a negative immediate on the logical forms stays clear in the upper half, since sign-extending it would set bits 31 to 16. It also checks that a right shift of a value with bit 31 set fills with zeros rather than copying the sign. Branches are exercised both forward and as a backward counted loop: a wrong offset base or a missing shift by two either skips the wrong instruction or loops the wrong number of times. Writes to register 0, and undefined op and funct codes (including codes close to the store encoding), are checked for leaving registers and memory untouched while the PC still advances.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
// sc_pkg: shared encodings and control bundle for the single-cycle core.
// Assumes the fixed 32-bit instruction layout with the major code in [31:26].
package sc_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;

    // Major codes (instruction bits [31:26])
    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_JMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ  = 6'h04;
    localparam logic [5:0] OPC_BNE  = 6'h05;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_ANDI = 6'h0C;
    localparam logic [5:0] OPC_ORI  = 6'h0D;
    localparam logic [5:0] OPC_LW   = 6'h23;
    localparam logic [5:0] OPC_SW   = 6'h2B;

    // Function codes for register-format words (bits [5:0])
    localparam logic [5:0] FN_SLL = 6'h00;
    localparam logic [5:0] FN_SRL = 6'h02;
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_NOR = 6'h27;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_NOR,
        ALU_SHL,
        ALU_SHR
    } alu_op_e;

    // Per-instruction control derived by the decoder
    typedef struct packed {
        logic    reg_we;    // write a result into the register file
        logic    dst_rd;    // destination is rd (else rt)
        logic    src_imm;   // second ALU operand is the extended immediate
        logic    imm_zext;  // zero-extend the immediate (else sign-extend)
        alu_op_e alu_op;
        logic    mem_rd;    // write-back takes the loaded word
        logic    mem_we;    // store rt into the data store
        logic    br_eq;     // branch when operands equal
        logic    br_ne;     // branch when operands differ
        logic    jump;      // unconditional long jump
    } ctl_t;

endpackage

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
// sc_decode: turns the major and function codes into a control bundle.
// Assumes any code not listed decodes to an all-zero bundle, i.e. a no-op.
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opc,
    input  logic [5:0] fn,
    output ctl_t       ctl
);

    // Purpose: combinational decode of one instruction word
    always_comb begin
        ctl = '0;
        ctl.alu_op = ALU_ADD;
        case (opc)
            OPC_REG: begin
                ctl.dst_rd = 1'b1;
                case (fn)
                    FN_ADD:  begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_ADD; end
                    FN_SUB:  begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_SUB; end
                    FN_AND:  begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_AND; end
                    FN_OR:   begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_OR;  end
                    FN_NOR:  begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_NOR; end
                    FN_SLL:  begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_SHL; end
                    FN_SRL:  begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_SHR; end
                    default: ctl.reg_we = 1'b0;
                endcase
            end
            OPC_ADDI: begin
                ctl.reg_we  = 1'b1;
                ctl.src_imm = 1'b1;
                ctl.alu_op  = ALU_ADD;
            end
            OPC_ANDI: begin
                ctl.reg_we   = 1'b1;
                ctl.src_imm  = 1'b1;
                ctl.imm_zext = 1'b1;
                ctl.alu_op   = ALU_AND;
            end
            OPC_ORI: begin
                ctl.reg_we   = 1'b1;
                ctl.src_imm  = 1'b1;
                ctl.imm_zext = 1'b1;
                ctl.alu_op   = ALU_OR;
            end
            OPC_LW: begin
                ctl.reg_we  = 1'b1;
                ctl.src_imm = 1'b1;
                ctl.mem_rd  = 1'b1;
            end
            OPC_SW: begin
                ctl.src_imm = 1'b1;
                ctl.mem_we  = 1'b1;
            end
            OPC_BEQ: ctl.br_eq = 1'b1;
            OPC_BNE: ctl.br_ne = 1'b1;
            OPC_JMP: ctl.jump  = 1'b1;
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
// sc_regfile: NREG x W register file, two operand read ports, one debug
// read port, one write port committed on the rising edge.
// Assumes entry 0 is constant zero; it has no storage and ignores writes.
module sc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    parameter int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] ra_dbg,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    output logic [W-1:0]  rd_dbg,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs_q [1:NREG-1];

    // Purpose: read one entry, forcing index zero to the constant
    function automatic logic [W-1:0] rd_port(input logic [AW-1:0] idx);
        if (idx == '0) return '0;
        return regs_q[idx];
    endfunction

    // Purpose: clear on reset, then commit one write per edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i < NREG; i++) regs_q[i] <= '0;
        end else if (we && wa != '0) begin
            regs_q[wa] <= wd;
        end
    end

    assign rd_a   = rd_port(ra_a);
    assign rd_b   = rd_port(ra_b);
    assign rd_dbg = rd_port(ra_dbg);

endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
// sc_alu: combinational datapath for add, subtract, logic ops and shifts.
// Assumes shifts act on operand b by shamt; sums wrap with no flag.
module sc_alu
    import sc_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [SW-1:0]  shamt,
    output logic [W-1:0]   y
);

    // Purpose: select the result for the requested operation
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_NOR: y = ~(a | b);
            ALU_SHL: y = b << shamt;
            ALU_SHR: y = b >> shamt;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/sc_wordmem.sv
`timescale 1ns/1ps
// sc_wordmem: WORDS x W word store, asynchronous read, edge-committed write.
// CLEAR_ON_RESET picks a variant that zeroes every word during reset;
// the other variant keeps its contents through reset.
module sc_wordmem #(
    parameter int WORDS          = 64,
    parameter int W              = 32,
    parameter bit CLEAR_ON_RESET = 1'b0,
    parameter int AW             = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem_q [WORDS];

    if (CLEAR_ON_RESET) begin : g_clear
        // Purpose: zero the array in reset, else commit a write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
            end else if (we) begin
                mem_q[waddr] <= wdata;
            end
        end
    end else begin : g_keep
        logic unused_rst;
        assign unused_rst = rst_n;
        // Purpose: commit a write regardless of reset
        always_ff @(posedge clk) begin
            if (we) mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
// sc_core: single-cycle 32-bit core. Fetch, decode, register read, ALU,
// data access and write-back all settle within one clock period; the PC,
// register file and data store update on the rising edge.
// Assumes programs are loaded through prog_* while rst_n is low and that
// data accesses are word aligned (address bits [1:0] are ignored).
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          prog_we,
    input  logic [$clog2(IMEM_WORDS)-1:0] prog_addr,
    input  logic [31:0]                   prog_data,
    input  logic [4:0]                    dbg_reg_sel,
    output logic [31:0]                   dbg_reg_data,
    output logic [31:0]                   dbg_pc
);

    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] instr;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] dmem_rdata;
    logic [XLEN-1:0] wb_data;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] j_target;
    logic [RIDX-1:0] wb_addr;
    logic            rf_we;
    logic            dmem_we;
    logic            take_branch;
    ctl_t            ctl;

    // Instruction store: keeps its program through reset
    sc_wordmem #(
        .WORDS          (IMEM_WORDS),
        .W              (XLEN),
        .CLEAR_ON_RESET (1'b0)
    ) u_imem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (prog_we),
        .waddr (prog_addr),
        .wdata (prog_data),
        .raddr (pc_q[IAW+1:2]),
        .rdata (instr)
    );

    sc_decode u_dec (
        .opc (instr[31:26]),
        .fn  (instr[5:0]),
        .ctl (ctl)
    );

    assign rf_we   = ctl.reg_we;
    assign dmem_we = ctl.mem_we;
    assign wb_addr = ctl.dst_rd ? instr[15:11] : instr[20:16];
    assign wb_data = ctl.mem_rd ? dmem_rdata : alu_y;

    sc_regfile #(
        .NREG (32),
        .W    (XLEN)
    ) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_a   (instr[25:21]),
        .ra_b   (instr[20:16]),
        .ra_dbg (dbg_reg_sel),
        .rd_a   (rs_val),
        .rd_b   (rt_val),
        .rd_dbg (dbg_reg_data),
        .we     (rf_we),
        .wa     (wb_addr),
        .wd     (wb_data)
    );

    // Purpose: extend the 16-bit constant per the decoded form
    always_comb begin
        if (ctl.imm_zext) imm_ext = {16'b0, instr[15:0]};
        else              imm_ext = {{16{instr[15]}}, instr[15:0]};
    end

    assign alu_b = ctl.src_imm ? imm_ext : rt_val;

    sc_alu #(
        .W (XLEN)
    ) u_alu (
        .op    (ctl.alu_op),
        .a     (rs_val),
        .b     (alu_b),
        .shamt (instr[10:6]),
        .y     (alu_y)
    );

    // Data store: cleared by reset, word indexed by the byte address
    sc_wordmem #(
        .WORDS          (DMEM_WORDS),
        .W              (XLEN),
        .CLEAR_ON_RESET (1'b1)
    ) u_dmem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dmem_we),
        .waddr (alu_y[DAW+1:2]),
        .wdata (rt_val),
        .raddr (alu_y[DAW+1:2]),
        .rdata (dmem_rdata)
    );

    assign pc_plus4    = pc_q + 32'd4;
    assign br_target   = pc_plus4 + {imm_ext[29:0], 2'b00};
    assign j_target    = {pc_plus4[31:28], instr[25:0], 2'b00};
    assign take_branch = (ctl.br_eq && (rs_val == rt_val)) ||
                         (ctl.br_ne && (rs_val != rt_val));

    // Purpose: choose the address of the next instruction
    always_comb begin
        if (ctl.jump)        pc_next = j_target;
        else if (take_branch) pc_next = br_target;
        else                  pc_next = pc_plus4;
    end

    // Purpose: program counter register
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assign dbg_pc = pc_q;

    logic unused_bits;
    assign unused_bits = ^{pc_q[1:0], pc_q[31:IAW+2], alu_y[1:0], alu_y[31:DAW+2]};

endmodule

// File: rtl/sc_core_chk.sv
`timescale 1ns/1ps
// sc_core_chk: protocol checks on the core's PC sequencing, register-zero
// reads and write enables. Attached to every sc_core by the bind below.
module sc_core_chk
    import sc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] pc,
    input  logic [31:0] instr,
    input  logic [31:0] rs_val,
    input  logic [31:0] rt_val,
    input  logic        rf_we,
    input  logic        dmem_we
);

    logic [5:0]  opc;
    logic [5:0]  fn;
    logic [31:0] seq_pc;
    logic [31:0] exp_br;
    logic [31:0] exp_jmp;
    logic        known;

    assign opc     = instr[31:26];
    assign fn      = instr[5:0];
    assign seq_pc  = pc + 32'd4;
    assign exp_br  = seq_pc + {{14{instr[15]}}, instr[15:0], 2'b00};
    assign exp_jmp = {seq_pc[31:28], instr[25:0], 2'b00};

    // Purpose: flag the codes the core is meant to execute
    always_comb begin
        case (opc)
            OPC_REG: known = (fn == FN_ADD) || (fn == FN_SUB) || (fn == FN_AND) ||
                             (fn == FN_OR)  || (fn == FN_NOR) || (fn == FN_SLL) ||
                             (fn == FN_SRL);
            OPC_JMP, OPC_BEQ, OPC_BNE, OPC_ADDI, OPC_ANDI,
            OPC_ORI, OPC_LW, OPC_SW: known = 1'b1;
            default: known = 1'b0;
        endcase
    end

    p_zero_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[25:21] == 5'd0) |-> (rs_val == 32'd0));

    p_seq_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (opc != OPC_JMP && opc != OPC_BEQ && opc != OPC_BNE) |=> (pc == $past(seq_pc)));

    p_jump_tgt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_JMP) |=> (pc == $past(exp_jmp)));

    p_beq_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_BEQ && rs_val == rt_val) |=> (pc == $past(exp_br)));

    p_bne_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_BNE && rs_val == rt_val) |=> (pc == $past(seq_pc)));

    p_undef_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !known |-> (!rf_we && !dmem_we));

    p_store_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (opc == OPC_SW));

endmodule

bind sc_core sc_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pc      (pc_q),
    .instr   (instr),
    .rs_val  (rs_val),
    .rt_val  (rt_val),
    .rf_we   (rf_we),
    .dmem_we (dmem_we)
);

// File: tb/sc_core_tb_top.sv
`timescale 1ns/1ps
// sc_core_tb_top: directed bench. Each task loads a short program, runs it
// and compares registers read through the debug port with hand-computed values.
module sc_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [31:0] prog_data = '0;
    logic [4:0]  dbg_reg_sel = '0;
    logic [31:0] dbg_reg_data;
    logic [31:0] dbg_pc;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] pbuf [64];
    int          plen = 0;

    sc_core dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .prog_we      (prog_we),
        .prog_addr    (prog_addr),
        .prog_data    (prog_data),
        .dbg_reg_sel  (dbg_reg_sel),
        .dbg_reg_data (dbg_reg_data),
        .dbg_pc       (dbg_pc)
    );

    // 50 MHz clock
    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    function automatic logic [31:0] enc_r(int fn, int rs, int rt, int rd, int sh);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
    endfunction

    function automatic logic [31:0] enc_i(int opc, int rs, int rt, int imm);
        return {opc[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    function automatic logic [31:0] enc_j(int tgt);
        return {6'h02, tgt[25:0]};
    endfunction

    task automatic emit(logic [31:0] w);
        pbuf[plen] = w;
        plen++;
    endtask

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_reg(string req, int r, logic [31:0] exp);
        dbg_reg_sel = r[4:0];
        #1;
        check(req, $sformatf("reg %0d", r), dbg_reg_data, exp);
    endtask

    // Load pbuf plus a self-jump under reset, release, run some cycles
    task automatic run_prog(int cycles);
        emit(enc_j(plen));
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < plen; i++) begin
            prog_we   = 1'b1;
            prog_addr = i[5:0];
            prog_data = pbuf[i];
            @(negedge clk);
        end
        prog_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (cycles) @(negedge clk);
        plen = 0;
    endtask

    task automatic t_arith();
        emit(enc_i(8'h08, 0, 1, 5));
        emit(enc_i(8'h08, 0, 2, 16'hFFFD));
        emit(enc_r(6'h20, 1, 2, 3, 0));
        emit(enc_r(6'h22, 2, 1, 4, 0));
        emit(enc_i(8'h08, 0, 5, 16'hFFFF));
        emit(enc_i(8'h08, 0, 6, 1));
        emit(enc_r(6'h20, 5, 6, 7, 0));
        emit(enc_r(6'h00, 0, 6, 9, 31));
        emit(enc_i(8'h08, 9, 10, 16'hFFFF));
        emit(enc_r(6'h20, 10, 6, 11, 0));
        emit(enc_r(6'h22, 9, 6, 12, 0));
        emit(enc_i(8'h08, 0, 13, 16'h7FFF));
        run_prog(40);
        chk_reg("R6", 2, 32'hFFFF_FFFD);
        chk_reg("R3", 3, 32'd2);
        chk_reg("R3", 4, 32'hFFFF_FFF8);
        chk_reg("R3", 7, 32'd0);
        chk_reg("R3", 11, 32'h8000_0000);
        chk_reg("R3", 12, 32'h7FFF_FFFF);
        chk_reg("R3", 13, 32'h0000_7FFF);
    endtask

    task automatic t_logic();
        emit(enc_i(8'h0D, 0, 1, 16'hF0F0));
        emit(enc_i(8'h0D, 0, 2, 16'hFF00));
        emit(enc_r(6'h24, 1, 2, 3, 0));
        emit(enc_r(6'h25, 1, 2, 4, 0));
        emit(enc_r(6'h27, 1, 2, 5, 0));
        emit(enc_r(6'h27, 1, 0, 6, 0));
        emit(enc_i(8'h0C, 5, 7, 16'h8001));
        emit(enc_i(8'h0D, 0, 8, 16'h8000));
        run_prog(30);
        chk_reg("R4", 3, 32'h0000_F000);
        chk_reg("R4", 4, 32'h0000_FFF0);
        chk_reg("R4", 5, 32'hFFFF_000F);
        chk_reg("R4", 6, 32'hFFFF_0F0F);
        chk_reg("R6", 7, 32'h0000_0001);
        chk_reg("R6", 8, 32'h0000_8000);
    endtask

    task automatic t_shift();
        emit(enc_i(8'h0D, 0, 1, 16'h8421));
        emit(enc_r(6'h00, 0, 1, 2, 4));
        emit(enc_r(6'h02, 0, 2, 3, 8));
        emit(enc_r(6'h00, 0, 1, 4, 16));
        emit(enc_r(6'h02, 0, 4, 5, 31));
        run_prog(20);
        chk_reg("R5", 2, 32'h0008_4210);
        chk_reg("R5", 3, 32'h0000_0842);
        chk_reg("R5", 4, 32'h8421_0000);
        chk_reg("R5", 5, 32'h0000_0001);
    endtask

    task automatic t_zero_reg();
        emit(enc_i(8'h08, 0, 0, 7));
        emit(enc_i(8'h0D, 0, 0, 16'hFFFF));
        emit(enc_r(6'h20, 0, 0, 1, 0));
        emit(enc_i(8'h08, 0, 2, 3));
        emit(enc_r(6'h25, 2, 2, 0, 0));
        emit(enc_r(6'h20, 0, 2, 3, 0));
        run_prog(20);
        chk_reg("R2", 0, 32'd0);
        chk_reg("R2", 1, 32'd0);
        chk_reg("R2", 3, 32'd3);
    endtask

    task automatic t_mem();
        emit(enc_i(8'h08, 0, 1, 16));
        emit(enc_i(8'h0D, 0, 2, 16'hBEEF));
        emit(enc_i(8'h2B, 1, 2, 8));
        emit(enc_i(8'h2B, 1, 1, 16'hFFFC));
        emit(enc_i(8'h23, 0, 3, 24));
        emit(enc_i(8'h23, 0, 4, 12));
        emit(enc_i(8'h23, 1, 5, 4));
        emit(enc_i(8'h23, 1, 6, 16'hFFF8));
        run_prog(30);
        chk_reg("R7", 3, 32'h0000_BEEF);
        chk_reg("R7", 4, 32'd16);
        chk_reg("R1", 5, 32'd0);
        chk_reg("R1", 6, 32'd0);
    endtask

    task automatic t_branch();
        emit(enc_i(8'h08, 0, 1, 1));
        emit(enc_i(8'h08, 0, 2, 1));
        emit(enc_i(8'h04, 1, 2, 1));
        emit(enc_i(8'h08, 0, 3, 99));
        emit(enc_i(8'h08, 0, 4, 7));
        emit(enc_i(8'h05, 1, 2, 1));
        emit(enc_i(8'h08, 0, 5, 5));
        emit(enc_i(8'h08, 0, 6, 3));
        emit(enc_i(8'h08, 6, 6, 16'hFFFF));
        emit(enc_i(8'h08, 7, 7, 2));
        emit(enc_i(8'h05, 6, 0, 16'hFFFD));
        run_prog(60);
        chk_reg("R8", 3, 32'd0);
        chk_reg("R8", 4, 32'd7);
        chk_reg("R8", 5, 32'd5);
        chk_reg("R8", 6, 32'd0);
        chk_reg("R8", 7, 32'd6);
        check("R8", "halt pc", dbg_pc, 32'd44);
    endtask

    task automatic t_jump();
        emit(enc_j(3));
        emit(enc_i(8'h08, 0, 1, 11));
        emit(enc_i(8'h08, 0, 2, 22));
        emit(enc_i(8'h08, 0, 3, 33));
        run_prog(20);
        chk_reg("R9", 1, 32'd0);
        chk_reg("R9", 2, 32'd0);
        chk_reg("R9", 3, 32'd33);
        check("R9", "self-jump pc", dbg_pc, 32'd16);
    endtask

    task automatic t_undef();
        emit(enc_i(8'h08, 0, 4, 9));
        emit(enc_i(8'h3F, 0, 1, 16'h1234));
        emit(enc_r(6'h3F, 4, 4, 2, 0));
        emit(enc_i(8'h2F, 4, 5, 0));
        emit(enc_i(8'h2A, 0, 4, 0));
        emit(enc_i(8'h23, 0, 6, 8));
        emit(enc_i(8'h08, 0, 3, 1));
        run_prog(20);
        chk_reg("R10", 1, 32'd0);
        chk_reg("R10", 2, 32'd0);
        chk_reg("R10", 5, 32'd0);
        chk_reg("R10", 6, 32'd0);
        chk_reg("R10", 3, 32'd1);
        check("R10", "pc after no-ops", dbg_pc, 32'd28);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            prog_we   = 1'b1;
            prog_addr = i[5:0];
            prog_data = 32'h0;
            @(negedge clk);
        end
        prog_we = 1'b0;
        prog_addr = 6'd8;
        prog_data = enc_j(8);
        prog_we = 1'b1;
        @(negedge clk);
        prog_we = 1'b0;
        check("R1", "pc in reset", dbg_pc, 32'd0);
        chk_reg("R1", 3, 32'd0);
        chk_reg("R1", 4, 32'd0);
        chk_reg("R12", 0, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R11", "pc after three steps", dbg_pc, 32'd12);
        check("R12", "debug pc", dbg_pc, 32'h0000_000C);
    endtask

    initial begin
        t_arith();
        t_reset();
        t_logic();
        t_shift();
        t_zero_reg();
        t_mem();
        t_branch();
        t_jump();
        t_undef();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule